// File: doc/BRIEF.md
# Time-Pulse Coded Continuous Logic Unit

This block evaluates continuous-logic operations (minimum, maximum, absolute difference, equivalence, complement and their combinations) on two scalar operands. It does this without an adder or comparator in the result path. Each operand becomes the width of a single high pulse. The pulse begins at the start of a frame that lasts a fixed number of clocks.

A programmable two-input Boolean cell combines the two pulses on every clock tick. A 4-bit tuning word selects which of the sixteen binary functions the cell applies. Because the pulses are aligned at the frame start, the count of ticks where the cell output is high is a continuous-logic function of the two widths. For example, the AND function yields min(a,b) and the XOR function yields |a-b|.

A width counter accumulates the high ticks of the cell output. It registers the total at frame end and raises a one-cycle strobe with it. Operands and the tuning word are captured once per frame, so every frame applies exactly one function to one operand pair.

Top module: `tpc_logic_unit`

## Requirements
- R1: While reset is asserted and during the first frame after its release, `resultValid` is 0, `resultOut` is 0 and both operand pulses are low. The first reported result after reset is 0.
- R2: A frame lasts T = 2^FRAME_BITS clocks, which is 16 by default. `resultValid` is high for exactly one cycle per frame, in the first cycle of the frame, and is low in the other T-1 cycles.
- R3: An operand value v is coded as a pulse that is high on frame ticks 0 to v-1 and low for the rest of the frame. A value of T or more keeps the pulse high for the whole frame.
- R4: The cell output on each tick is tune[{bBit,aBit}]. Bit 0 gives the output when both pulses are low. Bit 1 gives it when only operand A is high, bit 2 when only operand B is high, and bit 3 when both are high.
- R5: `resultOut` equals the number of ticks in a frame on which the cell output was high. It is updated in the first cycle of the following frame, together with `resultValid`. The count restarts from 0 for every frame.
- R6: Tune 4'b1000 (AND) gives min(a,b). Tune 4'b1110 (OR) gives max(a,b).
- R7: Tune 4'b0110 (XOR) gives |a-b|. Tune 4'b1001 (equivalence) gives T-|a-b|.
- R8: Tune 4'b0111 (NAND) gives T-min(a,b). Tune 4'b0001 (NOR) gives T-max(a,b). Tune 4'b0101 gives T-a, the complement of operand A.
- R9: `opA`, `opB` and `tune` are sampled only in the last cycle of a frame and are used for the whole next frame. Changes earlier in a frame have no effect. Values present in the last cycle of frame F produce the result reported in the first cycle of frame F+2.
- R10: All sixteen tune codes give the count defined by R4 and R5, for every operand pair in 0..T.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | FRAME_BITS+1 | Operand A, 0..T (larger values saturate) |
| opB | input | FRAME_BITS+1 | Operand B, 0..T (larger values saturate) |
| tune | input | 4 | Function select, indexed by {bBit,aBit} |
| pulseA | output | 1 | Pulse-width coded operand A for the current frame |
| pulseB | output | 1 | Pulse-width coded operand B for the current frame |
| pulseOut | output | 1 | Cell output for the current tick |
| resultOut | output | FRAME_BITS+1 | Measured output width of the previous frame |
| resultValid | output | 1 | One-cycle strobe marking a new result |

## Verification
On every cycle, the assertions check the following frame-level behaviour:
- the tick counter steps through the frame and wraps back to 0;
- the captured operands and tuning word stay fixed inside a frame;
- each pulse is a single run that starts at tick 0;
- the accumulator never reaches T before the final tick;
- the result holds between strobes and the strobe never lasts two cycles.

The arithmetic meaning of the result cannot be shown by those properties. That covers min, max, difference and complement for each tune code, the saturation of oversized operands, and the two-frame latency with its immunity to changes in mid-frame. These are shown only by the bench, which sweeps every tune code over every operand pair and compares each count with a closed-form value.

// File: rtl/tpc_pkg.sv
`timescale 1ns/1ps
package tpc_pkg;

  // Strobes from the frame controller to the datapath
  typedef struct packed {
    logic frameFirst;  // tick 0 of the frame
    logic frameLast;   // final tick of the frame; capture and close point
  } ctrlStrobes_t;

  localparam int TUNE_W = 4;

endpackage

// File: rtl/tpc_frame_ctrl.sv
`timescale 1ns/1ps
module tpc_frame_ctrl
  import tpc_pkg::*;
#(
  parameter int FRAME_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  output logic [FRAME_BITS-1:0] tick,
  output ctrlStrobes_t          strobes
);

  localparam logic [FRAME_BITS-1:0] TICK_LAST = {FRAME_BITS{1'b1}};
  localparam logic [FRAME_BITS-1:0] TICK_ONE  = FRAME_BITS'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tick <= '0;
    else       tick <= tick + TICK_ONE;
  end

  always_comb begin
    strobes.frameFirst = (tick == '0);
    strobes.frameLast  = (tick == TICK_LAST);
  end

  // R2
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.frameLast |=> (tick == '0));

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.frameLast |=> (tick == $past(tick) + TICK_ONE));

endmodule

// File: rtl/tpc_pulse_encoder.sv
`timescale 1ns/1ps
module tpc_pulse_encoder
  import tpc_pkg::*;
#(
  parameter int FRAME_BITS = 4,
  parameter int OP_W       = FRAME_BITS + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [FRAME_BITS-1:0] tick,
  input  logic [OP_W-1:0]       opIn,
  output logic                  pulse
);

  logic [OP_W-1:0] heldOp;

  // Operand captured only at the close of a frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  heldOp <= '0;
    else if (strobes.frameLast) heldOp <= opIn;
  end

  // High on ticks 0 .. heldOp-1; values of T or more cover the frame
  assign pulse = ({1'b0, tick} < heldOp);

  // R9
  held_op_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.frameLast |=> $stable(heldOp));

  // R3
  pulse_single_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pulse && !strobes.frameLast) |=> !pulse);

  // R3
  pulse_starts_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.frameFirst && heldOp != '0) |-> pulse);

endmodule

// File: rtl/tpc_bool_cell.sv
`timescale 1ns/1ps
module tpc_bool_cell
  import tpc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [TUNE_W-1:0] tuneIn,
  input  logic              aBit,
  input  logic              bBit,
  output logic              cellBit
);

  logic [TUNE_W-1:0] heldTune;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  heldTune <= '0;
    else if (strobes.frameLast) heldTune <= tuneIn;
  end

  // Truth-table lookup: the operand bits form the row index
  assign cellBit = heldTune[{bBit, aBit}];

  // R9
  held_tune_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.frameLast |=> $stable(heldTune));

endmodule

// File: rtl/tpc_datapath.sv
`timescale 1ns/1ps
module tpc_datapath
  import tpc_pkg::*;
#(
  parameter int FRAME_BITS = 4,
  parameter int OP_W       = FRAME_BITS + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [FRAME_BITS-1:0] tick,
  input  logic [OP_W-1:0]       opA,
  input  logic [OP_W-1:0]       opB,
  input  logic [TUNE_W-1:0]     tune,
  output logic                  pulseA,
  output logic                  pulseB,
  output logic                  cellBit,
  output logic [OP_W-1:0]       resultOut,
  output logic                  resultValid
);

  localparam int              NUM_OPS   = 2;
  localparam logic [OP_W-1:0] FRAME_LEN = OP_W'(2 ** FRAME_BITS);

  logic [NUM_OPS-1:0][OP_W-1:0] opVec;
  logic [NUM_OPS-1:0]           pulseVec;
  logic [OP_W-1:0]              widthAcc;
  logic [OP_W-1:0]              widthNext;

  assign opVec[0] = opA;
  assign opVec[1] = opB;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_enc
    tpc_pulse_encoder #(
      .FRAME_BITS (FRAME_BITS),
      .OP_W       (OP_W)
    ) u_enc (
      .clk     (clk),
      .rstN    (rstN),
      .strobes (strobes),
      .tick    (tick),
      .opIn    (opVec[i]),
      .pulse   (pulseVec[i])
    );
  end

  assign pulseA = pulseVec[0];
  assign pulseB = pulseVec[1];

  tpc_bool_cell u_cell (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .tuneIn  (tune),
    .aBit    (pulseVec[0]),
    .bBit    (pulseVec[1]),
    .cellBit (cellBit)
  );

  // Width counter: the final tick's bit is folded into the registered result
  assign widthNext = widthAcc + {{(OP_W-1){1'b0}}, cellBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthAcc    <= '0;
      resultOut   <= '0;
      resultValid <= 1'b0;
    end else if (strobes.frameLast) begin
      widthAcc    <= '0;
      resultOut   <= widthNext;
      resultValid <= 1'b1;
    end else begin
      widthAcc    <= widthNext;
      resultValid <= 1'b0;
    end
  end

  // R5
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    widthAcc < FRAME_LEN);

  // R5
  result_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultOut <= FRAME_LEN);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.frameLast |=> $stable(resultOut));

  // R2
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R5
  acc_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.frameLast |=> (widthAcc == '0));

endmodule

// File: rtl/tpc_logic_unit.sv
`timescale 1ns/1ps
module tpc_logic_unit
  import tpc_pkg::*;
#(
  parameter int FRAME_BITS = 4,
  parameter int OP_W       = FRAME_BITS + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  input  logic [TUNE_W-1:0] tune,
  output logic              pulseA,
  output logic              pulseB,
  output logic              pulseOut,
  output logic [OP_W-1:0]   resultOut,
  output logic              resultValid
);

  logic [FRAME_BITS-1:0] tick;
  ctrlStrobes_t          strobes;

  tpc_frame_ctrl #(
    .FRAME_BITS (FRAME_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .strobes (strobes)
  );

  tpc_datapath #(
    .FRAME_BITS (FRAME_BITS),
    .OP_W       (OP_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .tick        (tick),
    .opA         (opA),
    .opB         (opB),
    .tune        (tune),
    .pulseA      (pulseA),
    .pulseB      (pulseB),
    .cellBit     (pulseOut),
    .resultOut   (resultOut),
    .resultValid (resultValid)
  );

endmodule

// File: tb/test_tpc_logic_unit.sv
`timescale 1ns/1ps
module test_tpc_logic_unit;

  localparam int FRAME_BITS = 4;
  localparam int OP_W       = FRAME_BITS + 1;
  localparam int T          = 2 ** FRAME_BITS;
  localparam int WATCH      = 190000;

  typedef struct {
    int a;
    int b;
    int y;
    int e;
    bit g;
  } caseRec_t;

  logic            clk = 1'b0;
  logic            rstN;
  logic [OP_W-1:0] opA;
  logic [OP_W-1:0] opB;
  logic [3:0]      tune;
  logic            pulseA;
  logic            pulseB;
  logic            pulseOut;
  logic [OP_W-1:0] resultOut;
  logic            resultValid;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;
  caseRec_t pipe0;
  caseRec_t pipe1;

  always #2.5 clk = ~clk;

  tpc_logic_unit #(.FRAME_BITS(FRAME_BITS)) i_tpc_logic_unit (
    .clk         (clk),
    .rstN        (rstN),
    .opA         (opA),
    .opB         (opB),
    .tune        (tune),
    .pulseA      (pulseA),
    .pulseB      (pulseB),
    .pulseOut    (pulseOut),
    .resultOut   (resultOut),
    .resultValid (resultValid)
  );

  function automatic int clampT(int v);
    return (v > T) ? T : v;
  endfunction

  // Closed-form count of cell-high ticks from the four region lengths (R4, R5)
  function automatic int expOf(int a, int b, int y);
    int ac, bc, mn, mx;
    ac = clampT(a);
    bc = clampT(b);
    mn = (ac < bc) ? ac : bc;
    mx = (ac > bc) ? ac : bc;
    return y[3] * mn + y[1] * (ac - mn) + y[2] * (bc - mn) + y[0] * (T - mx);
  endfunction

  function automatic string tagFor(caseRec_t c);
    if (c.g) return "R9";
    case (c.y)
      4'b1000, 4'b1110:          return "R4/R6";
      4'b0110, 4'b1001:          return "R4/R7";
      4'b0111, 4'b0001, 4'b0101: return "R4/R8";
      default:                   return "R4/R10";
    endcase
  endfunction

  // Entered on the first cycle of a frame, where a result is due
  task automatic stepFrame(int na, int nb, int ny, bit glitch);
    int cntA = 0, cntB = 0, extraValid = 0;
    bit lowA = 0, lowB = 0, brokeA = 0, brokeB = 0;
    // R5: result of the frame that just closed
    total++;
    if (resultValid !== 1'b1 || resultOut !== OP_W'(pipe1.e)) begin
      bad++;
      $display("FAIL %s R5: a=%0d b=%0d tune=%b got result=%0d valid=%b expected result=%0d valid=1",
               tagFor(pipe1), pipe1.a, pipe1.b, pipe1.y[3:0], resultOut, resultValid, pipe1.e);
    end
    pipe1 = pipe0;
    pipe0 = '{a: na, b: nb, y: ny, e: expOf(na, nb, ny), g: glitch};
    opA  = OP_W'(na);
    opB  = OP_W'(nb);
    tune = ny[3:0];
    for (int t = 0; t < T; t++) begin
      if (pulseA) begin cntA++; if (lowA) brokeA = 1; end else lowA = 1;
      if (pulseB) begin cntB++; if (lowB) brokeB = 1; end else lowB = 1;
      if (glitch && t == 6) begin
        opA  = OP_W'(T + 7);
        opB  = '0;
        tune = ~ny[3:0];
      end
      if (glitch && t == T - 3) begin
        opA  = OP_W'(na);
        opB  = OP_W'(nb);
        tune = ny[3:0];
      end
      @(negedge clk);
      if (t < T - 1 && resultValid) extraValid++;
    end
    // R2: no strobe inside the frame
    total++;
    if (extraValid != 0) begin
      bad++;
      $display("FAIL R2: strobe seen %0d times mid-frame, expected 0", extraValid);
    end
    // R3: pulse lengths and single run from tick 0
    total++;
    if (cntA != clampT(pipe1.a) || cntB != clampT(pipe1.b) || brokeA || brokeB) begin
      bad++;
      $display("FAIL R3: widths a=%0d b=%0d split=%0d/%0d expected a=%0d b=%0d split=0/0",
               cntA, cntB, brokeA, brokeB, clampT(pipe1.a), clampT(pipe1.b));
    end
  endtask

  initial begin
    repeat (WATCH) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    opA  = '0;
    opB  = '0;
    tune = '0;
    repeat (4) @(negedge clk);
    // R1: held in reset
    total++;
    if (resultValid !== 1'b0 || resultOut !== '0 || pulseA !== 1'b0 || pulseB !== 1'b0) begin
      bad++;
      $display("FAIL R1: in reset valid=%b result=%0d pulses=%b%b expected valid=0 result=0 pulses=00",
               resultValid, resultOut, pulseA, pulseB);
    end
    rstN = 1'b1;
    // R1: first frame after release carries no strobe
    for (int t = 0; t < T; t++) begin
      total++;
      if (resultValid !== 1'b0 || resultOut !== '0) begin
        bad++;
        $display("FAIL R1: first frame tick %0d valid=%b result=%0d expected valid=0 result=0",
                 t, resultValid, resultOut);
      end
      @(negedge clk);
    end
    // Frames 0 and 1 use the reset-held zeros: both results are 0 (R1)
    pipe1 = '{a: 0, b: 0, y: 0, e: 0, g: 0};
    pipe0 = '{a: 0, b: 0, y: 0, e: 0, g: 0};

    // R10: every tune code over every operand pair in 0..T
    for (int y = 0; y < 16; y++)
      for (int a = 0; a <= T; a++)
        for (int b = 0; b <= T; b++)
          stepFrame(a, b, y, 1'b0);

    // R3: operands above T saturate
    stepFrame(T + 5, 3, 4'b0110, 1'b0);
    stepFrame(2 * T - 1, 2 * T - 1, 4'b1000, 1'b0);
    stepFrame(7, T + 9, 4'b0101, 1'b0);

    // R9: mid-frame disturbance of every input, restored before capture
    stepFrame(5, 9, 4'b1000, 1'b1);
    stepFrame(12, 4, 4'b1001, 1'b1);
    stepFrame(0, T, 4'b0110, 1'b1);

    // Drain the two cases still in flight
    stepFrame(0, 0, 0, 1'b0);
    stepFrame(0, 0, 0, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule